// File: doc/BRIEF.md
# Per-Port Byte Parity Checker and Generator

This block sits in the data path of one port of a 36-bit buffer. The word is handled as a row of 9-bit lanes, each with eight data bits and one parity bit. On every word that passes, the block checks the parity of each lane against the selected sense and raises one error flag if any lane is wrong. The check never changes the data.

When regeneration is enabled, the block replaces the parity bit of every lane with a freshly computed one that satisfies the selected sense. The data bits pass through unchanged. When regeneration is off, the word passes through bit for bit, including the stored parity bits.

A sense input picks odd or even parity for both checking and generation. One instance serves each port. The path is purely combinational, so the flag and the output word follow the inputs in the same cycle. Storage and mailbox logic sit outside this block.

Top module: `par_guard`

## Requirements
- R1: The word is split into lanes of 9 bits. Lane k occupies bits [9k+8:9k], with bit 9k+8 as the lane's parity bit and bits [9k+7:9k] as its data. The default has four lanes, bits 35..0.
- R2: With `odd_sel_i`=1 a lane is correct when its nine bits hold an odd number of ones. With `odd_sel_i`=0 a lane is correct when they hold an even number.
- R3: `parity_err_o` is 1 in the same cycle exactly when at least one lane of `word_i` fails the check of R2.
- R4: A parity failure has no effect on the data. With `gen_en_i`=0 and a failing lane, `word_o` still equals `word_i`.
- R5: With `gen_en_i`=1, every lane of `word_o` holds a count of ones that matches the selected sense.
- R6: With `gen_en_i`=1, the eight data bits of every lane of `word_o` equal those of `word_i`.
- R7: With `gen_en_i`=0, `word_o` equals `word_i` bit for bit, including the parity bits.
- R8: The error flag is computed from `word_i` whatever the value of `gen_en_i`, so a bad input lane still raises it while generation repairs the output.
- R9: The sense select flips the verdict for every lane. An all-zero word raises no error under even sense and raises the error under odd sense. Under odd sense with generation on, it comes out with only each lane's parity bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 36 | Word presented at the port, four 9-bit lanes |
| gen_en_i | input | 1 | 1: replace each lane's parity bit on the output |
| odd_sel_i | input | 1 | Parity sense: 1 odd, 0 even |
| word_o | output | 36 | Word passed on, with parity bits regenerated when enabled |
| parity_err_o | output | 1 | 1 when any lane of word_i fails its check |

## Verification
Both results are combinational, so the error flag and the output word are due in the same cycle as the input that causes them, with zero register stages. The bench applies each input set on the falling clock edge and samples one nanosecond later, well inside that half period. It compares both outputs with values from its own functions. Directed words cover the all-zero sense flip, a single corrupted lane in each position, and a bad lane while generation is on. Seeded random words cover the remaining mixes of sense and enable.

// File: rtl/par_guard_pkg.sv
// Package: shared defaults and the parity-sense encoding for the parity guard.
// Assumes: the lane parity bit is the most significant bit of each lane.
package par_guard_pkg;
    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 9;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } sense_e;
endpackage

// File: rtl/par_lane.sv
// Module: par_lane
// Checks one lane against the selected parity sense and, when enabled,
// rebuilds that lane's parity bit. Purely combinational.
// Assumes: bit LANE_W-1 is the parity bit; the lower bits are data.
module par_lane
    import par_guard_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic              gen_en_i,
    input  sense_e            sense_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              bad_o
);
    localparam int unsigned DATA_W = LANE_W - 1;

    logic [DATA_W-1:0] data_bits;
    logic              fresh_par;

    // Split data bits off and compute the parity bit that meets the sense
    always_comb begin
        data_bits = lane_i[DATA_W-1:0];
        fresh_par = (^data_bits) ^ sense_i;
    end

    // Passive check: the whole lane's XOR must match the sense
    always_comb begin
        bad_o = (^lane_i) ^ sense_i;
    end

    // Output lane: data unchanged, parity either kept or regenerated
    always_comb begin
        lane_o = gen_en_i ? {fresh_par, data_bits} : lane_i;
    end
endmodule

// File: rtl/par_err_merge.sv
// Module: par_err_merge
// Collapses the per-lane failure bits into a single error flag.
// Assumes: a lane failure is signalled active high.
module par_err_merge #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] bad_i,
    output logic         any_o
);
    // Any failing lane raises the flag
    always_comb begin
        any_o = |bad_i;
    end
endmodule

// File: rtl/par_guard.sv
// Module: par_guard (top)
// Parity path for one port: checks every lane of the incoming word without
// touching it and, on request, regenerates each lane's parity bit.
// Assumes: word_i is stable for the cycle in which the outputs are used;
// the block holds no state, so it needs neither clock nor reset.
module par_guard
    import par_guard_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic [LANES*LANE_W-1:0] word_i,
    input  logic                    gen_en_i,
    input  logic                    odd_sel_i,
    output logic [LANES*LANE_W-1:0] word_o,
    output logic                    parity_err_o
);
    localparam int unsigned WORD_W = LANES * LANE_W;

    sense_e             sense;
    logic [LANES-1:0]   lane_bad;
    logic [WORD_W-1:0]  word_out;

    // Map the raw select onto the sense encoding
    always_comb begin
        sense = sense_e'(odd_sel_i);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        par_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .lane_i   (word_i[k*LANE_W +: LANE_W]),
            .gen_en_i (gen_en_i),
            .sense_i  (sense),
            .lane_o   (word_out[k*LANE_W +: LANE_W]),
            .bad_o    (lane_bad[k])
        );
    end

    par_err_merge #(
        .N (LANES)
    ) u_merge (
        .bad_i (lane_bad),
        .any_o (parity_err_o)
    );

    // Drive the output word from the lane outputs
    always_comb begin
        word_o = word_out;
    end
endmodule

// File: rtl/par_guard_chk.sv
// Module: par_guard_chk
// Assertion checker for par_guard, attached by bind. Relates the ports only.
// Assumes: inputs may be unknown before the bench first drives them, so
// every check waits until its inputs are known.
module par_guard_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input logic [LANES*LANE_W-1:0] word_i,
    input logic                    gen_en_i,
    input logic                    odd_sel_i,
    input logic [LANES*LANE_W-1:0] word_o,
    input logic                    parity_err_o
);
    localparam int unsigned DATA_W = LANE_W - 1;

    // Port-level consistency checks, evaluated on every input change
    always_comb begin
        if (!$isunknown({word_i, gen_en_i, odd_sel_i})) begin
            // R7
            if (!gen_en_i) begin
                passthru_chk: assert (word_o == word_i)
                    else $error("passthru: word_o differs with generation off");
            end
            for (int k = 0; k < LANES; k++) begin
                if (gen_en_i) begin
                    // R6
                    data_keep_chk: assert (word_o[k*LANE_W +: DATA_W] == word_i[k*LANE_W +: DATA_W])
                        else $error("data bits altered in lane %0d", k);
                    // R5
                    lane_sense_chk: assert ((($countones(word_o[k*LANE_W +: LANE_W]) % 2) == 1) == odd_sel_i)
                        else $error("regenerated lane %0d misses sense", k);
                end
            end
        end
    end

    logic any_fail;

    // Count failing input lanes from the sense rule
    always_comb begin
        any_fail = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if ((($countones(word_i[k*LANE_W +: LANE_W]) % 2) == 1) != odd_sel_i)
                any_fail = 1'b1;
        end
    end

    // Error flag against the lane-count rule
    always_comb begin
        if (!$isunknown({word_i, odd_sel_i})) begin
            // R3
            err_flag_chk: assert (parity_err_o == any_fail)
                else $error("parity_err_o=%0b expected %0b", parity_err_o, any_fail);
        end
    end
endmodule

bind par_guard par_guard_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .word_i       (word_i),
    .gen_en_i     (gen_en_i),
    .odd_sel_i    (odd_sel_i),
    .word_o       (word_o),
    .parity_err_o (parity_err_o)
);

// File: tb/par_guard_tb.sv
// Bench for par_guard: directed corner cases plus seeded random words,
// compared with expected values from bench functions.
module par_guard_tb;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int W     = LANES * LW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_i = '0;
    logic         gen_en_i = 1'b0;
    logic         odd_sel_i = 1'b0;
    logic [W-1:0] word_o;
    logic         parity_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    par_guard u_dut (
        .word_i       (word_i),
        .gen_en_i     (gen_en_i),
        .odd_sel_i    (odd_sel_i),
        .word_o       (word_o),
        .parity_err_o (parity_err_o)
    );

    // Expected flag: any lane whose ones count disagrees with the sense
    function automatic logic exp_err(input logic [W-1:0] w, input logic odd);
        for (int k = 0; k < LANES; k++)
            if ((($countones(w[k*LW +: LW]) % 2) == 1) != odd) return 1'b1;
        return 1'b0;
    endfunction

    // Expected output word from the enable and sense rules
    function automatic logic [W-1:0] exp_out(input logic [W-1:0] w, input logic gen, input logic odd);
        logic [W-1:0] r;
        r = w;
        if (gen) begin
            for (int k = 0; k < LANES; k++) begin
                r[k*LW + LW-1] = ((($countones(w[k*LW +: LW-1]) % 2) == 1) != odd);
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] w, input logic gen, input logic odd);
        @(negedge clk);
        word_i = w; gen_en_i = gen; odd_sel_i = odd;
        #1;
    endtask

    task automatic check_both(input string req);
        chk({req, " out"}, word_o, exp_out(word_i, gen_en_i, odd_sel_i));
        chk({req, " err"}, {{(W-1){1'b0}}, parity_err_o}, {{(W-1){1'b0}}, exp_err(word_i, odd_sel_i)});
    endtask

    initial begin
        int unsigned seed;
        logic [W-1:0] w;
        logic [W-1:0] clean;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: zeros under even sense, no error, zero out
        apply('0, 1'b0, 1'b0);
        chk("R9 idle out", word_o, '0);
        chk("R9 idle err", {{(W-1){1'b0}}, parity_err_o}, '0);

        // R9: same word, odd sense, flags the error
        apply('0, 1'b0, 1'b1);
        chk("R9 odd zeros err", {{(W-1){1'b0}}, parity_err_o}, {{(W-1){1'b0}}, 1'b1});

        // R9/R5: odd sense generation sets only parity bits (36'h804020100)
        apply('0, 1'b1, 1'b1);
        chk("R9 R5 odd gen", word_o, 36'h804020100);

        // R1/R3/R4: corrupt one lane at a time (flip its parity bit) on a clean word
        clean = exp_out(36'h5A3C_96E1_F & {W{1'b1}}, 1'b1, 1'b0);
        for (int k = 0; k < LANES; k++) begin
            w = clean;
            w[k*LW + LW-1] = ~w[k*LW + LW-1];
            apply(w, 1'b0, 1'b0);
            chk("R1 R3 lane err", {{(W-1){1'b0}}, parity_err_o}, {{(W-1){1'b0}}, 1'b1});
            chk("R4 R7 data kept", word_o, w);
            // R8: generation repairs output, flag still reflects the input
            apply(w, 1'b1, 1'b0);
            chk("R8 err with gen", {{(W-1){1'b0}}, parity_err_o}, {{(W-1){1'b0}}, 1'b1});
            chk("R5 R6 repaired", word_o, clean);
        end

        // R3: a clean word raises no flag
        apply(clean, 1'b0, 1'b0);
        chk("R3 clean err", {{(W-1){1'b0}}, parity_err_o}, '0);

        // R2 R5 R6 R7: seeded random mixes
        for (int n = 0; n < 600; n++) begin
            w = {$urandom(), $urandom()};
            apply(w, 1'($urandom() % 2), 1'($urandom() % 2));
            check_both("R2 R5 R6 R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule